// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler Tree

This block turns one fast system clock into a family of single-cycle clock-enable pulses for the bus domains of a chip. A first divider produces the core/system-bus enable at a power-of-two fraction of the system clock, between 1 and 512. Two peripheral-bus dividers sit behind it in cascade. Each counts only the cycles in which the system-bus enable is high, and divides that rate by 1, 2, 4, 8 or 16. Because every divided rate is derived from the system clock, no configuration can produce a rate faster than the system clock.

Each peripheral bus also drives a timer enable. When that bus divider is 1, the timer enable matches the bus enable. Otherwise the timer enable runs at twice the bus rate. Software writes ratio codes at any time. Each divider takes a new code only at the end of the period it is currently running, so no enable interval is cut short. A status output reports the ratios in effect as base-two logarithms.

Top module: `bus_clk_prescaler`

## Requirements
- R1: After reset every ratio in effect is 1. All three shift status outputs read 0, and all five enables are high in every cycle.
- R2: The 4-bit system-bus code selects the ratio A. Codes 0000 through 0111 give 1. Codes 1000, 1001, 1010 and 1011 give 2, 4, 8 and 16. Codes 1100, 1101, 1110 and 1111 give 64, 128, 256 and 512. The hclk enable is high for one cycle in every A system-clock cycles, and the hclk shift status reports log2(A).
- R3: Each 3-bit peripheral-bus code selects the ratio P. Codes 000 through 011 give 1, and code 1ss gives 2^(ss+1). The bus enable then pulses once every A·P system-clock cycles, and that bus's shift status reports log2(P).
- R4: A peripheral-bus enable is never high in a cycle where the hclk enable is low.
- R5: A timer enable pulses every A cycles when its bus ratio P is 1, and every A·P/2 cycles otherwise. Every cycle with a bus enable pulse also has a timer enable pulse on that bus.
- R6: The two peripheral-bus dividers are independent. Any pair of their codes gives each bus the period that its own code alone implies.
- R7: A change of the system-bus code has no effect until the next hclk pulse. The period in progress completes with the old ratio, and the status keeps the old value until that pulse.
- R8: A change of a peripheral-bus code has no effect until that bus's next enable pulse. Its period in progress completes with the old ratio, and its status keeps the old value until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ahbCode | input | 4 | Requested system-bus ratio code |
| apb1Code | input | 3 | Requested low-speed peripheral-bus ratio code |
| apb2Code | input | 3 | Requested high-speed peripheral-bus ratio code |
| hclkEn | output | 1 | System-bus clock enable |
| pclk1En | output | 1 | Low-speed peripheral-bus clock enable |
| pclk2En | output | 1 | High-speed peripheral-bus clock enable |
| tim1En | output | 1 | Timer enable on the low-speed bus |
| tim2En | output | 1 | Timer enable on the high-speed bus |
| ahbShift | output | 4 | log2 of the system-bus ratio in effect |
| apb1Shift | output | 3 | log2 of the low-speed bus ratio in effect |
| apb2Shift | output | 3 | log2 of the high-speed bus ratio in effect |

## Verification
The hardest situation to reach is a code change that lands partway through a long division period. The change must be deferred until that period ends. The stimulus waits for an enable pulse, waits a few more cycles, and then rewrites the code. It then checks two things: the status still shows the old ratio, and the interval that was already running finishes at its old length before the new one starts. A second difficulty is that an update of the system-bus ratio can fall inside a peripheral period. For this reason every measurement waits until all three status fields show the new setting, and then starts from a fresh pulse.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

  localparam int AHB_CODE_W    = 4;
  localparam int APB_CODE_W    = 3;
  localparam int AHB_MAX_SHIFT = 9;
  localparam int APB_MAX_SHIFT = 4;
  localparam int NUM_APB       = 2;
  localparam int AHB_SHIFT_W   = $clog2(AHB_MAX_SHIFT + 1);
  localparam int APB_SHIFT_W   = $clog2(APB_MAX_SHIFT + 1);
  localparam int AHB_CNT_W     = AHB_MAX_SHIFT;
  localparam int APB_CNT_W     = APB_MAX_SHIFT;

  typedef logic [AHB_SHIFT_W-1:0] ahbShift_t;
  typedef logic [APB_SHIFT_W-1:0] apbShift_t;

  // Ratios in effect, driven by control toward the datapath
  typedef struct packed {
    ahbShift_t                  ahbShift;
    logic [NUM_APB-1:0][APB_SHIFT_W-1:0] apbShift;
  } ratioSel_t;

  // Period boundaries, returned by the datapath to control
  typedef struct packed {
    logic               ahbEdge;
    logic [NUM_APB-1:0] apbEdge;
  } edgeStrobe_t;

  // 0xxx -> 0; 10ss -> ss+1; 11ss -> ss+6 (a divide-by-32 step is skipped)
  function automatic ahbShift_t decodeAhb(input logic [AHB_CODE_W-1:0] code);
    ahbShift_t s;
    if (!code[3])      s = '0;
    else if (!code[2]) s = ahbShift_t'({2'b00, code[1:0]} + 4'd1);
    else               s = ahbShift_t'({2'b00, code[1:0]} + 4'd6);
    return s;
  endfunction

  // 0xx -> 0; 1ss -> ss+1
  function automatic apbShift_t decodeApb(input logic [APB_CODE_W-1:0] code);
    apbShift_t s;
    if (!code[2]) s = '0;
    else          s = apbShift_t'({1'b0, code[1:0]} + 3'd1);
    return s;
  endfunction

  // Terminal count (2^shift - 1) as a run of low-order ones
  function automatic logic [AHB_CNT_W-1:0] maskAhb(input ahbShift_t s);
    logic [AHB_CNT_W-1:0] m;
    for (int i = 0; i < AHB_CNT_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  function automatic logic [APB_CNT_W-1:0] maskApb(input apbShift_t s);
    logic [APB_CNT_W-1:0] m;
    for (int i = 0; i < APB_CNT_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

endpackage

// File: rtl/presc_apb_stage.sv
module presc_apb_stage
  import busclk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  apbShift_t shift,
  output logic      busEn,
  output logic      timEn
);

  logic [APB_CNT_W-1:0] cnt;
  logic [APB_CNT_W-1:0] termMask;
  logic [APB_CNT_W-1:0] halfMask;

  assign termMask = maskApb(shift);
  assign halfMask = termMask >> 1;

  // The timer taps the counter at half the bus period. With shift 0
  // both masks are zero and the timer follows every tick.
  assign busEn = tick && (cnt == termMask);
  assign timEn = tick && ((cnt & halfMask) == halfMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == termMask) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termMask);

  assert_tim_with_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    busEn |-> timEn);

endmodule

// File: rtl/presc_divider_path.sv
module presc_divider_path
  import busclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ratioSel_t          sel,
  output logic               hclkEn,
  output logic [NUM_APB-1:0] pclkEn,
  output logic [NUM_APB-1:0] timEn,
  output edgeStrobe_t        edges
);

  logic [AHB_CNT_W-1:0] ahbCnt;
  logic [AHB_CNT_W-1:0] ahbMask;

  assign ahbMask = maskAhb(sel.ahbShift);
  assign hclkEn  = (ahbCnt == ahbMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ahbCnt <= '0;
    else if (hclkEn) ahbCnt <= '0;
    else             ahbCnt <= ahbCnt + 1'b1;
  end

  assert_ahb_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    ahbCnt <= ahbMask);

  for (genvar g = 0; g < NUM_APB; g++) begin : g_apb
    presc_apb_stage u_stage (
      .clk   (clk),
      .rstN  (rstN),
      .tick  (hclkEn),
      .shift (sel.apbShift[g]),
      .busEn (pclkEn[g]),
      .timEn (timEn[g])
    );

    assert_pclk_in_hclk_R4: assert property (@(posedge clk) disable iff (!rstN)
      pclkEn[g] |-> hclkEn);
  end

  assign edges.ahbEdge = hclkEn;
  assign edges.apbEdge = pclkEn;

endmodule

// File: rtl/presc_ratio_ctrl.sv
module presc_ratio_ctrl
  import busclk_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [AHB_CODE_W-1:0]               ahbCode,
  input  logic [NUM_APB-1:0][APB_CODE_W-1:0]  apbCode,
  input  edgeStrobe_t                         edges,
  output ratioSel_t                           sel
);

  ahbShift_t                           ahbQ;
  logic [NUM_APB-1:0][APB_SHIFT_W-1:0] apbQ;

  // A ratio is replaced only on the last cycle of its running period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ahbQ <= '0;
      apbQ <= '0;
    end else begin
      if (edges.ahbEdge) ahbQ <= decodeAhb(ahbCode);
      for (int i = 0; i < NUM_APB; i++) begin
        if (edges.apbEdge[i]) apbQ[i] <= decodeApb(apbCode[i]);
      end
    end
  end

  assign sel.ahbShift = ahbQ;
  assign sel.apbShift = apbQ;

  assert_ahb_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !edges.ahbEdge |=> $stable(sel.ahbShift));

  for (genvar g = 0; g < NUM_APB; g++) begin : g_hold
    assert_apb_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      !edges.apbEdge[g] |=> $stable(sel.apbShift[g]));
  end

endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
  import busclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] ahbCode,
  input  logic [2:0] apb1Code,
  input  logic [2:0] apb2Code,
  output logic       hclkEn,
  output logic       pclk1En,
  output logic       pclk2En,
  output logic       tim1En,
  output logic       tim2En,
  output logic [3:0] ahbShift,
  output logic [2:0] apb1Shift,
  output logic [2:0] apb2Shift
);

  logic [NUM_APB-1:0][APB_CODE_W-1:0] apbCodeVec;
  ratioSel_t          sel;
  edgeStrobe_t        edges;
  logic [NUM_APB-1:0] pclkVec;
  logic [NUM_APB-1:0] timVec;

  assign apbCodeVec[0] = apb1Code;
  assign apbCodeVec[1] = apb2Code;

  presc_ratio_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ahbCode (ahbCode),
    .apbCode (apbCodeVec),
    .edges   (edges),
    .sel     (sel)
  );

  presc_divider_path u_path (
    .clk    (clk),
    .rstN   (rstN),
    .sel    (sel),
    .hclkEn (hclkEn),
    .pclkEn (pclkVec),
    .timEn  (timVec),
    .edges  (edges)
  );

  assign pclk1En   = pclkVec[0];
  assign pclk2En   = pclkVec[1];
  assign tim1En    = timVec[0];
  assign tim2En    = timVec[1];
  assign ahbShift  = sel.ahbShift;
  assign apb1Shift = sel.apbShift[0];
  assign apb2Shift = sel.apbShift[1];

endmodule

// File: tb/bus_clk_prescaler_tb.sv
module bus_clk_prescaler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] ahbCode = '0;
  logic [2:0] apb1Code = '0;
  logic [2:0] apb2Code = '0;
  logic       hclkEn, pclk1En, pclk2En, tim1En, tim2En;
  logic [3:0] ahbShift;
  logic [2:0] apb1Shift, apb2Shift;

  int nChecks = 0;
  int nFails  = 0;
  int alignErr = 0;
  int timErr   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_clk_prescaler u_dut (
    .clk(clk), .rstN(rstN), .ahbCode(ahbCode), .apb1Code(apb1Code),
    .apb2Code(apb2Code), .hclkEn(hclkEn), .pclk1En(pclk1En),
    .pclk2En(pclk2En), .tim1En(tim1En), .tim2En(tim2En),
    .ahbShift(ahbShift), .apb1Shift(apb1Shift), .apb2Shift(apb2Shift)
  );

  // Continuous monitor for R4 and R5 relationships
  always @(negedge clk) begin
    if (rstN) begin
      if ((pclk1En || pclk2En) && !hclkEn) alignErr++;
      if ((pclk1En && !tim1En) || (pclk2En && !tim2En)) timErr++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ahbRatio(input int c);
    if (c < 8)  return 1;
    if (c < 12) return 1 << (c - 7);
    return 1 << (c - 6);
  endfunction

  function automatic int apbRatio(input int c);
    return (c < 4) ? 1 : (1 << (c - 3));
  endfunction

  function automatic int log2i(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  function automatic logic sig(input int k);
    case (k)
      0: return hclkEn;
      1: return pclk1En;
      2: return pclk2En;
      3: return tim1En;
      default: return tim2En;
    endcase
  endfunction

  task automatic measureGap(input int k, output int gap);
    while (!sig(k)) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!sig(k));
  endtask

  task automatic applyAndCheck(input int a, input int p1, input int p2,
                               input string req);
    int aR, p1R, p2R, g;
    aR  = ahbRatio(a);
    p1R = apbRatio(p1);
    p2R = apbRatio(p2);
    ahbCode  = 4'(a);
    apb1Code = 3'(p1);
    apb2Code = 3'(p2);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (int'(ahbShift) == log2i(aR) && int'(apb1Shift) == log2i(p1R) &&
          int'(apb2Shift) == log2i(p2R)) break;
    end
    check(int'(ahbShift) == log2i(aR), "R2", "ahb shift status", ahbShift, log2i(aR));
    check(int'(apb1Shift) == log2i(p1R), "R3", "apb1 shift status", apb1Shift, log2i(p1R));
    check(int'(apb2Shift) == log2i(p2R), req, "apb2 shift status", apb2Shift, log2i(p2R));
    measureGap(0, g);
    check(g == aR, "R2", "hclk period", g, aR);
    measureGap(1, g);
    check(g == aR * p1R, "R3", "pclk1 period", g, aR * p1R);
    measureGap(2, g);
    check(g == aR * p2R, req, "pclk2 period", g, aR * p2R);
    measureGap(3, g);
    check(g == ((p1R == 1) ? aR : aR * p1R / 2), "R5", "tim1 period", g,
          (p1R == 1) ? aR : aR * p1R / 2);
    measureGap(4, g);
    check(g == ((p2R == 1) ? aR : aR * p2R / 2), "R5", "tim2 period", g,
          (p2R == 1) ? aR : aR * p2R / 2);
  endtask

  task automatic runAll();
    int gap;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check({hclkEn, pclk1En, pclk2En, tim1En, tim2En} == 5'b11111, "R1",
            "enables after reset", {hclkEn, pclk1En, pclk2En, tim1En, tim2En}, 31);
      check(ahbShift == 0 && apb1Shift == 0 && apb2Shift == 0, "R1",
            "status after reset", {ahbShift, apb1Shift, apb2Shift}, 0);
      @(negedge clk);
    end

    // R2: every system-bus code with unit peripheral ratios
    for (int a = 0; a < 16; a++) applyAndCheck(a, 0, 0, "R2");

    // R3, R6: all pairs of peripheral codes behind a divide-by-2 system bus
    for (int p1 = 0; p1 < 8; p1++)
      for (int p2 = 0; p2 < 8; p2++)
        applyAndCheck(8, p1, p2, "R6");

    // R3, R5: deep cascade
    applyAndCheck(13, 7, 5, "R3");

    // R7: system-bus change in mid-period
    applyAndCheck(10, 0, 0, "R7");
    while (!hclkEn) @(negedge clk);
    gap = 0;
    repeat (3) begin @(negedge clk); gap++; end
    ahbCode = 4'd8;
    @(negedge clk); gap++;
    check(ahbShift == 3, "R7", "status before boundary", ahbShift, 3);
    while (!hclkEn) begin @(negedge clk); gap++; end
    check(gap == 8, "R7", "period in progress", gap, 8);
    measureGap(0, gap);
    check(gap == 2, "R7", "period after boundary", gap, 2);
    check(ahbShift == 1, "R7", "status after boundary", ahbShift, 1);

    // R8: peripheral-bus change in mid-period
    applyAndCheck(8, 6, 0, "R8");
    while (!pclk1En) @(negedge clk);
    gap = 0;
    repeat (2) begin @(negedge clk); gap++; end
    apb1Code = 3'd4;
    @(negedge clk); gap++;
    check(apb1Shift == 3, "R8", "status before boundary", apb1Shift, 3);
    while (!pclk1En) begin @(negedge clk); gap++; end
    check(gap == 16, "R8", "period in progress", gap, 16);
    measureGap(1, gap);
    check(gap == 4, "R8", "period after boundary", gap, 4);
    check(apb1Shift == 1, "R8", "status after boundary", apb1Shift, 1);

    check(alignErr == 0, "R4", "bus pulses outside hclk", alignErr, 0);
    check(timErr == 0, "R5", "bus pulses without timer pulse", timErr, 0);
    done = 1;
  endtask

  initial begin
    fork
      runAll();
      begin repeat (WATCHDOG) @(posedge clk); end
    join_any
    disable fork;
    if (!done) check(1'b0, "watchdog", "run completed", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule